// File: doc/BRIEF.md
# PCI Interrupt Line Router

The block collects eight shared, level-sensitive PCI interrupt request lines, labelled A to H, and maps them onto 24 global interrupt levels. Each line always drives its own input in the upper (APIC) range of the outputs. A per-line route byte can also steer the line onto one of the sixteen lower (legacy) pins. Several lines may land on the same legacy pin, and that pin then acts as a wired-OR of them.

A power-management event level is also merged into the outputs. A small select field chooses which output carries it. Moving that field while the event is asserted moves the event with it: it drops from the old output and appears on the new one in the same cycle.

Software programs the route bytes and the event select through a plain write port. Every output is computed combinationally from the stored settings and the input levels, then registered once, so that downstream controllers see clean levels.

Top module: `pirq_router`

## Requirements
- R1: Line n (n = 0..7, A..H) drives output 16+n whenever it is high, whatever its route byte holds. An APIC-range output is low when its line is low and the event is not targeted there. The route byte for lines A..D is at write address 0x0..0x3; for lines E..H it is at 0x8..0xB.
- R2: When route bit 7 is 0 and the IRQ field in route bits [4:0] is below 16, the line is also ORed onto legacy output pin equal to that field.
- R3: When route bit 7 is 1, the line reaches no legacy pin.
- R4: When route bit 7 is 0 and the IRQ field is 16..31, the line reaches no legacy pin.
- R5: A legacy pin is the OR of every line routed to it. Lines from both groups may share a pin.
- R6: Route bits [6:5] are ignored.
- R7: The event select is bits [2:0] written at address 0x4. Codes 0, 1, 2, 4 and 5 set the target output to 9, 10, 11, 20 and 21 respectively. After reset the target is 9.
- R8: Codes 3, 6 and 7 are reserved and leave the current target unchanged.
- R9: The event level is ORed onto its target output together with any line contributions to that output.
- R10: If the target changes while the event is asserted, the old output loses the event and the new output gains it in the same cycle.
- R11: Reset sets every route byte to 0x80 (legacy routing off), restores the event target to 9 and drives all outputs low.
- R12: An output change appears one clock after the input change that causes it. A register write takes effect on the outputs one clock after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pirq_in | input | 8 | Interrupt request levels, bit n is line n |
| sci_in | input | 1 | Power-management event level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| gsi_out | output | 24 | Registered global interrupt levels |

## Verification
The bench builds the block with its default of eight lines, sixteen legacy pins and a five-bit IRQ field. At that size every value of the IRQ field, including the 16..31 range that must stay off the legacy side, can be swept on every line with the disable bit both set and clear. With all lines piled onto one pin, every one of the 256 request patterns can be applied, which covers sharing completely. All eight select codes are walked with the event asserted, and one retarget is made while the event stays high.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

  localparam int RT_IRQ_W   = 5;
  localparam int PIN_IDX_W  = 5;
  localparam int SEL_W      = 3;

  typedef struct packed {
    logic                dis;
    logic [RT_IRQ_W-1:0] irq;
  } route_t;

  localparam route_t ROUTE_RESET = '{dis: 1'b1, irq: '0};
  localparam logic [PIN_IDX_W-1:0] SCI_TGT_RESET = PIN_IDX_W'(9);

  typedef struct packed {
    logic                 valid;
    logic [PIN_IDX_W-1:0] tgt;
  } sci_dec_t;

  function automatic sci_dec_t sci_decode(input logic [SEL_W-1:0] code);
    sci_dec_t d;
    d.valid = 1'b1;
    unique case (code)
      3'd0:    d.tgt = PIN_IDX_W'(9);
      3'd1:    d.tgt = PIN_IDX_W'(10);
      3'd2:    d.tgt = PIN_IDX_W'(11);
      3'd4:    d.tgt = PIN_IDX_W'(20);
      3'd5:    d.tgt = PIN_IDX_W'(21);
      default: begin
        d.valid = 1'b0;
        d.tgt   = '0;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pirq_rst_sync.sv
module pirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ   = 8,
  parameter int GRP_SIZE   = 4,
  parameter int GRP_STRIDE = 8,
  parameter int SCI_ADDR   = 4,
  parameter int ADDR_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_sync_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [7:0]                 wr_data,
  output route_t [NUM_PIRQ-1:0]      routes,
  output logic   [PIN_IDX_W-1:0]     sci_tgt
);

  localparam int DIS_BIT = 7;

  logic unused_rsvd;
  assign unused_rsvd = ^wr_data[6:RT_IRQ_W];

  route_t wr_route;
  assign wr_route = '{dis: wr_data[DIS_BIT], irq: wr_data[RT_IRQ_W-1:0]};

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_line
    localparam int LINE_ADDR = (n / GRP_SIZE) * GRP_STRIDE + (n % GRP_SIZE);
    logic   hit;
    route_t route_d, route_q;

    assign hit = wr_en && (wr_addr == ADDR_W'(LINE_ADDR));

    always_comb begin
      route_d = route_q;
      if (hit) route_d = wr_route;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) route_q <= ROUTE_RESET;
      else             route_q <= route_d;
    end

    assign routes[n] = route_q;
  end

  logic                 sci_hit;
  sci_dec_t             sci_dec;
  logic [PIN_IDX_W-1:0] tgt_d, tgt_q;

  assign sci_hit = wr_en && (wr_addr == ADDR_W'(SCI_ADDR));
  assign sci_dec = sci_decode(wr_data[SEL_W-1:0]);

  always_comb begin
    tgt_d = tgt_q;
    if (sci_hit && sci_dec.valid) tgt_d = sci_dec.tgt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) tgt_q <= SCI_TGT_RESET;
    else             tgt_q <= tgt_d;
  end

  assign sci_tgt = tgt_q;

endmodule

// File: rtl/pirq_gsi_merge.sv
module pirq_gsi_merge
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ    = 8,
  parameter int LEGACY_PINS = 16,
  parameter int NUM_GSI     = LEGACY_PINS + NUM_PIRQ
) (
  input  route_t [NUM_PIRQ-1:0]  routes,
  input  logic   [NUM_PIRQ-1:0]  pirq_in,
  input  logic                   sci_in,
  input  logic   [PIN_IDX_W-1:0] sci_tgt,
  output logic   [NUM_GSI-1:0]   gsi_d
);

  for (genvar g = 0; g < NUM_GSI; g++) begin : g_pin
    logic sci_here;
    assign sci_here = sci_in && (sci_tgt == PIN_IDX_W'(g));

    if (g < LEGACY_PINS) begin : g_legacy
      logic [NUM_PIRQ-1:0] sel;
      for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_src
        assign sel[n] = !routes[n].dis && (routes[n].irq == RT_IRQ_W'(g));
      end
      assign gsi_d[g] = |(sel & pirq_in) | sci_here;
    end else if (g - LEGACY_PINS < NUM_PIRQ) begin : g_apic
      assign gsi_d[g] = pirq_in[g - LEGACY_PINS] | sci_here;
    end else begin : g_spare
      assign gsi_d[g] = sci_here;
    end
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ    = 8,
  parameter int LEGACY_PINS = 16,
  parameter int GRP_SIZE    = 4,
  parameter int GRP_STRIDE  = 8,
  parameter int SCI_ADDR    = 4,
  parameter int ADDR_W      = 4,
  localparam int NUM_GSI    = LEGACY_PINS + NUM_PIRQ
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PIRQ-1:0] pirq_in,
  input  logic                sci_in,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  output logic [NUM_GSI-1:0]  gsi_out
);

  logic                  rst_sync_n;
  route_t [NUM_PIRQ-1:0] routes;
  logic [PIN_IDX_W-1:0]  sci_tgt;
  logic [NUM_GSI-1:0]    gsi_d, gsi_q;

  pirq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pirq_route_regs #(
    .NUM_PIRQ   (NUM_PIRQ),
    .GRP_SIZE   (GRP_SIZE),
    .GRP_STRIDE (GRP_STRIDE),
    .SCI_ADDR   (SCI_ADDR),
    .ADDR_W     (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .routes     (routes),
    .sci_tgt    (sci_tgt)
  );

  pirq_gsi_merge #(
    .NUM_PIRQ    (NUM_PIRQ),
    .LEGACY_PINS (LEGACY_PINS),
    .NUM_GSI     (NUM_GSI)
  ) u_merge (
    .routes  (routes),
    .pirq_in (pirq_in),
    .sci_in  (sci_in),
    .sci_tgt (sci_tgt),
    .gsi_d   (gsi_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) gsi_q <= '0;
    else             gsi_q <= gsi_d;
  end

  assign gsi_out = gsi_q;

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ    = 8,
  parameter int LEGACY_PINS = 16,
  parameter int NUM_GSI     = 24
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic [NUM_PIRQ-1:0]  pirq_in,
  input logic                 sci_in,
  input logic [PIN_IDX_W-1:0] sci_tgt,
  input logic [NUM_GSI-1:0]   gsi_out
);

  logic past_valid;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) past_valid <= 1'b0;
    else             past_valid <= 1'b1;
  end

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_apic_chk
    assert_apic_follow_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
      past_valid && $past(pirq_in[n]) |-> gsi_out[LEGACY_PINS+n]);

    assert_apic_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
      past_valid && !$past(pirq_in[n]) &&
      !($past(sci_in) && ($past(sci_tgt) == PIN_IDX_W'(LEGACY_PINS+n)))
      |-> !gsi_out[LEGACY_PINS+n]);
  end

  assert_sci_on_target_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    past_valid && $past(sci_in) |-> gsi_out[$past(sci_tgt)]);

  assert_sci_target_legal_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sci_tgt == PIN_IDX_W'(9)  || sci_tgt == PIN_IDX_W'(10) ||
    sci_tgt == PIN_IDX_W'(11) || sci_tgt == PIN_IDX_W'(20) ||
    sci_tgt == PIN_IDX_W'(21));

  assert_idle_outputs_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    past_valid && ($past(pirq_in) == '0) && !$past(sci_in) |-> gsi_out == '0);

  assert_legacy_needs_source_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    past_valid && (|gsi_out[LEGACY_PINS-1:0]) |-> $past(|pirq_in) || $past(sci_in));

endmodule

bind pirq_router pirq_router_chk #(
  .NUM_PIRQ    (NUM_PIRQ),
  .LEGACY_PINS (LEGACY_PINS),
  .NUM_GSI     (NUM_GSI)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .pirq_in    (pirq_in),
  .sci_in     (sci_in),
  .sci_tgt    (sci_tgt),
  .gsi_out    (gsi_out)
);

// File: tb/tb_pirq_router.sv
module tb_pirq_router;

  logic        clk;
  logic        rst_n;
  logic [7:0]  pirq_in;
  logic        sci_in;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [23:0] gsi_out;

  int checks;
  int fails;
  bit finished;

  logic       sh_dis [8];
  logic [4:0] sh_irq [8];
  int         sh_tgt;

  pirq_router dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .pirq_in (pirq_in),
    .sci_in  (sci_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .gsi_out (gsi_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [23:0] model(input logic [7:0] p, input logic s);
    logic [23:0] e;
    e = '0;
    for (int n = 0; n < 8; n++) begin
      e[16+n] = e[16+n] | p[n];
      if (!sh_dis[n] && sh_irq[n] < 5'd16) e[sh_irq[n]] = e[sh_irq[n]] | p[n];
    end
    if (s) e[sh_tgt] = 1'b1;
    return e;
  endfunction

  task automatic check(input string req, input logic [23:0] exp);
    checks++;
    if (gsi_out !== exp) begin
      fails++;
      $display("FAIL %s: gsi_out=%06h expected=%06h", req, gsi_out, exp);
    end
  endtask

  task automatic shadow_reset();
    for (int n = 0; n < 8; n++) begin
      sh_dis[n] = 1'b1;
      sh_irq[n] = '0;
    end
    sh_tgt = 9;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_route(input int n, input logic [7:0] b);
    wr((n < 4) ? 4'(n) : 4'(8 + n - 4), b);
    sh_dis[n] = b[7];
    sh_irq[n] = b[4:0];
  endtask

  task automatic set_sci(input logic [2:0] code);
    wr(4'h4, {5'b0, code});
    case (code)
      3'd0: sh_tgt = 9;
      3'd1: sh_tgt = 10;
      3'd2: sh_tgt = 11;
      3'd4: sh_tgt = 20;
      3'd5: sh_tgt = 21;
      default: ;
    endcase
  endtask

  task automatic apply(input logic [7:0] p, input logic s);
    @(negedge clk);
    pirq_in = p; sci_in = s;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pirq_in = '0; sci_in = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    shadow_reset();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; finished = 1'b0;
    rst_n = 1'b0; pirq_in = '0; sci_in = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    shadow_reset();
    do_reset();

    // R11: outputs low after reset; routes default to disabled
    check("R11 reset outputs", 24'h0);
    apply(8'hFF, 1'b0);
    check("R11 default routes off, R1 apic", 24'hFF0000);
    apply(8'h00, 1'b0);

    // R2 R3 R4 sweep every line over every IRQ field value and disable state
    for (int n = 0; n < 8; n++) begin
      for (int v = 0; v < 32; v++) begin
        for (int d = 0; d < 2; d++) begin
          set_route(n, {d[0], 2'b00, v[4:0]});
          apply(8'(1 << n), 1'b0);
          if (d == 1)       check("R3 disabled route", model(8'(1 << n), 1'b0));
          else if (v >= 16) check("R4 out-of-range irq", model(8'(1 << n), 1'b0));
          else              check("R2 legacy route", model(8'(1 << n), 1'b0));
          apply(8'h00, 1'b0);
        end
      end
      set_route(n, 8'h80);
    end

    // R6 reserved route bits ignored
    set_route(2, 8'h65);
    apply(8'h04, 1'b0);
    check("R6 bits 6:5 ignored (enabled)", 24'h040020);
    set_route(2, 8'hE5);
    apply(8'h04, 1'b0);
    check("R6 bits 6:5 ignored (disabled)", 24'h040000);
    set_route(2, 8'h80);
    apply(8'h00, 1'b0);

    // R5 all lines share pin 7: every request pattern
    for (int n = 0; n < 8; n++) set_route(n, 8'h07);
    for (int p = 0; p < 256; p++) begin
      apply(8'(p), 1'b0);
      check("R5 wired-OR", model(8'(p), 1'b0));
    end
    // R5 lines from both groups on pin 3, others disabled
    for (int n = 0; n < 8; n++) set_route(n, 8'h80);
    set_route(0, 8'h03);
    set_route(4, 8'h03);
    apply(8'h10, 1'b0);
    check("R5 group E-H shares pin", 24'h100008);
    apply(8'h11, 1'b0);
    check("R5 both groups share pin", 24'h110008);
    set_route(0, 8'h80);
    set_route(4, 8'h80);
    apply(8'h00, 1'b0);

    // R7 R8 every select code with the event asserted
    apply(8'h00, 1'b1);
    check("R7 reset target is 9", 24'h000200);
    apply(8'h00, 1'b0);
    for (int c = 0; c < 8; c++) begin
      set_sci(3'd1);
      set_sci(3'(c));
      apply(8'h00, 1'b1);
      if (c == 3 || c > 5) check("R8 reserved code keeps target", model(8'h00, 1'b1));
      else                 check("R7 select code", model(8'h00, 1'b1));
      apply(8'h00, 1'b0);
    end

    // R9 event ORed with a line on the same pin
    set_route(0, 8'h0A);
    set_sci(3'd1);
    apply(8'h00, 1'b0);
    check("R9 none", 24'h000000);
    apply(8'h01, 1'b0);
    check("R9 line only", 24'h010400);
    apply(8'h00, 1'b1);
    check("R9 event only", 24'h000400);
    apply(8'h01, 1'b1);
    check("R9 both", 24'h010400);
    set_route(0, 8'h80);
    apply(8'h00, 1'b0);

    // R10 retarget while asserted; R12 write takes effect one clock later
    set_sci(3'd0);
    apply(8'h00, 1'b1);
    check("R10 before move", 24'h000200);
    set_sci(3'd4);
    check("R12 write not yet visible", 24'h000200);
    @(negedge clk);
    check("R10 moved to 20", 24'h100000);
    set_sci(3'd2);
    @(negedge clk);
    check("R10 moved to 11", 24'h000800);
    apply(8'h00, 1'b0);

    // R12 input latency of one clock
    @(negedge clk);
    pirq_in = 8'h80;
    #2;
    check("R12 unchanged before edge", 24'h000000);
    @(negedge clk);
    check("R12 one clock later", 24'h800000);
    apply(8'h00, 1'b0);

    // R11 reset mid-run restores defaults
    set_route(1, 8'h05);
    set_sci(3'd5);
    do_reset();
    check("R11 outputs low after reset", 24'h0);
    apply(8'h02, 1'b1);
    check("R11 routes and target restored", 24'h020200);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule